// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache

This block sits between a processor load/store port and a simple word-wide memory port. It holds 64 sets of four lines, and each line carries four 32-bit words. A request carries a 32-bit byte address. Bits [31:10] are the tag, bits [9:4] select the set, bits [3:2] select the word and bits [1:0] are the byte offset. On every request the four stored tags of the selected set are compared in parallel. A way hits only when its tag matches and its line is valid, and the hit is acknowledged combinationally in the same cycle.

On a miss the cache picks a victim way. The lowest-numbered invalid way is taken first. When every way is valid, the low two bits of a free-running 16-bit LFSR choose the way. Each word of a line has its own dirty flag, so before a refill only the modified words of the victim go back to memory, lowest word first. The cache then reads all four words of the new line, lowest word first. A mode pin selects the write policy. In write-back mode a store hit marks its word dirty. In write-through mode a store hit marks nothing dirty and is copied out on a separate posted-write strobe one cycle later. A flush pulse invalidates all lines, one set per cycle, and flags busy while it runs. Dirty contents are discarded by a flush.

Top module: `dcache4w`

## Requirements
- R1: Four lines whose addresses share bits [9:4] but differ in the tag (bits [31:10]) are all resident together after being loaded into an empty set, and each one then hits.
- R2: A request that hits asserts cpu_ack in the cycle the request is presented, with cpu_rdata equal to the addressed word, and produces no memory transaction.
- R3: A miss reads the whole line from memory in four transactions at the line-aligned addresses base, base+4, base+8 and base+12, in that order. It then acknowledges the request, and mem_req with mem_addr is held stable until mem_ack.
- R4: In write-back mode a store hit marks only its own word dirty. Evicting that line writes exactly the dirty words to memory (mem_we=1), in ascending word order, before the refill. The wt_we strobe never fires in this mode.
- R5: In write-through mode each acknowledged store raises wt_we for exactly one cycle, in the cycle after cpu_ack, with wt_addr and wt_data equal to the store's address and data. Such a store never causes a later memory write on eviction.
- R6: The victim is the lowest invalid way of the set when one exists, so filling an empty set never evicts a line that was just loaded.
- R7: A flush pulse accepted while idle raises busy for exactly 64 cycles. No request is acknowledged during that time, and afterwards every previously resident address misses.
- R8: After reset busy, cpu_ack, mem_req and wt_we are low and all lines are invalid.
- R9: Under a mixed random stream of loads and stores, each load returns the most recent value stored to that address, or the memory contents when no store was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wt_mode | input | 1 | 1 selects write-through, 0 selects write-back |
| flush | input | 1 | Pulse that starts invalidation of all lines |
| busy | output | 1 | High while the flush sweep runs |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Store data |
| cpu_ack | output | 1 | Request completed in this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ack |
| mem_req | output | 1 | Memory transaction request, held until mem_ack |
| mem_we | output | 1 | 1 for a memory write (write-back of a dirty word) |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the transaction in this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| wt_we | output | 1 | One-cycle write-through strobe |
| wt_addr | output | 32 | Write-through store address |
| wt_data | output | 32 | Write-through store data |

## Verification
Hit results are combinational, so the bench drives a request on the falling edge and samples cpu_ack and cpu_rdata a quarter period later, before the rising edge that commits it. A miss result appears only after the four refill transactions, plus any write-backs, have been acknowledged by the bench memory, which answers each request on its second falling edge. The bench counts the falling edges it waits and logs every memory transaction. The write-through strobe is registered, so it is checked on the falling edge right after the acknowledging rising edge and checked low one idle cycle later. Busy is sampled on each falling edge after the flush pulse and must stay high for exactly 64 of them.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVICT = 2'd1,
      ST_FILL  = 2'd2,
      ST_SWEEP = 2'd3
   } dc_state_t;
endpackage

// File: rtl/dc_lfsr.sv
module dc_lfsr #(
   parameter int         WIDTH = 16,
   parameter int         OUT_W = 2,
   parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);
   logic [WIDTH-1:0] taps;
   logic [WIDTH-1:0] lf_q;

   generate
      if (WIDTH == 16) begin : g_t16
         assign taps = WIDTH'(16'hB400);
      end else if (WIDTH == 8) begin : g_t8
         assign taps = WIDTH'(8'hB8);
      end else begin : g_bad
         $error("dc_lfsr: unsupported WIDTH");
         assign taps = '0;
      end
      if (OUT_W > WIDTH) begin : g_bad_out
         $error("dc_lfsr: OUT_W exceeds WIDTH");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lf_q <= SEED;
      else        lf_q <= (lf_q >> 1) ^ (lf_q[0] ? taps : '0);
   end

   assign rnd = lf_q[OUT_W-1:0];
endmodule

// File: rtl/dc_tag_cmp.sv
module dc_tag_cmp #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 22,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [WAYS-1:0]            valid,
   input  logic [TAG_W-1:0]           tag,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);
   logic [WAYS-1:0] match;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign match[w] = valid[w] && (tags[w] == tag);
      end
   endgenerate

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--)
         if (match[w]) hit_way = WAY_W'(w);
   end

   assign hit = |match;
endmodule

// File: rtl/dc_victim.sv
module dc_victim #(
   parameter int WAYS = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  valid,
   input  logic [WAY_W-1:0] rnd,
   output logic [WAY_W-1:0] way
);
   always_comb begin
      way = rnd;
      for (int w = WAYS - 1; w >= 0; w--)
         if (!valid[w]) way = WAY_W'(w);
   end
endmodule

// File: rtl/dcache4w.sv
module dcache4w
   import dc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SETS   = 64,
   parameter int WAYS   = 4,
   parameter int WORDS  = 4,
   parameter int RND_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wt_mode,
   input  logic              flush,
   output logic              busy,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              wt_we,
   output logic [ADDR_W-1:0] wt_addr,
   output logic [DATA_W-1:0] wt_data
);
   localparam int BOFF_W = $clog2(DATA_W / 8);
   localparam int WORD_W = $clog2(WORDS);
   localparam int SET_W  = $clog2(SETS);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int OFF_W  = WORD_W + BOFF_W;
   localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
   localparam logic [WORD_W-1:0] LAST_W = WORD_W'(WORDS - 1);
   localparam logic [SET_W-1:0]  LAST_S = SET_W'(SETS - 1);

   generate
      if ((SETS & (SETS - 1)) != 0 || SETS < 2) begin : g_bad_sets
         $error("dcache4w: SETS must be a power of two");
      end
      if ((WAYS & (WAYS - 1)) != 0 || WAYS < 2) begin : g_bad_ways
         $error("dcache4w: WAYS must be a power of two");
      end
      if ((WORDS & (WORDS - 1)) != 0 || WORDS < 2) begin : g_bad_words
         $error("dcache4w: WORDS must be a power of two");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("dcache4w: address too narrow for geometry");
      end
   endgenerate

   // storage
   logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
   logic [DATA_W-1:0] data_q  [SETS][WAYS][WORDS];
   logic [WAYS-1:0]   val_q   [SETS];
   logic [WORDS-1:0]  dirty_q [SETS][WAYS];

   dc_state_t         st;
   logic [WAY_W-1:0]  vway;
   logic [WORD_W-1:0] cnt;
   logic [SET_W-1:0]  fcnt;

   // address fields
   logic [SET_W-1:0]  set_i;
   logic [WORD_W-1:0] word_i;
   logic [TAG_W-1:0]  tag_i;
   assign set_i  = cpu_addr[OFF_W +: SET_W];
   assign word_i = cpu_addr[BOFF_W +: WORD_W];
   assign tag_i  = cpu_addr[ADDR_W-1 -: TAG_W];

   logic [WAYS-1:0][TAG_W-1:0] set_tags;
   logic [WAYS-1:0]            set_val;
   assign set_val = val_q[set_i];
   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_rd
         assign set_tags[w] = tag_q[set_i][w];
      end
   endgenerate

   logic             hit;
   logic [WAY_W-1:0] hway, pick, rnd;

   dc_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
      .tags(set_tags), .valid(set_val), .tag(tag_i), .hit(hit), .hit_way(hway));

   dc_lfsr #(.WIDTH(RND_W), .OUT_W(WAY_W)) u_rng (
      .clk(clk), .rst_n(rst_n), .rnd(rnd));

   dc_victim #(.WAYS(WAYS)) u_vic (.valid(set_val), .rnd(rnd), .way(pick));

   function automatic logic [WORD_W-1:0] low_one(input logic [WORDS-1:0] v);
      logic [WORD_W-1:0] r;
      r = '0;
      for (int i = WORDS - 1; i >= 0; i--)
         if (v[i]) r = WORD_W'(i);
      return r;
   endfunction

   logic [WORDS-1:0]  vdirty, pdirty, ev_mask;
   logic [WORD_W-1:0] ev_word;
   assign vdirty  = dirty_q[set_i][vway];
   assign pdirty  = dirty_q[set_i][pick] & {WORDS{set_val[pick]}};
   assign ev_word = low_one(vdirty);
   assign ev_mask = WORDS'(1) << ev_word;

   logic start, miss, hit_wr;
   assign start  = (st == ST_IDLE) && !flush && cpu_req;
   assign miss   = start && !hit;
   assign hit_wr = cpu_ack && cpu_we;

   assign cpu_ack   = start && hit;
   assign cpu_rdata = data_q[set_i][hway][word_i];
   assign busy      = (st == ST_SWEEP);
   assign mem_req   = (st == ST_EVICT) || (st == ST_FILL);
   assign mem_we    = (st == ST_EVICT);
   assign mem_addr  = (st == ST_EVICT)
                    ? {set_tags[vway], set_i, ev_word, {BOFF_W{1'b0}}}
                    : {tag_i, set_i, cnt, {BOFF_W{1'b0}}};
   assign mem_wdata = data_q[set_i][vway][ev_word];

   // control, valid and dirty state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         vway    <= '0;
         cnt     <= '0;
         fcnt    <= '0;
         wt_we   <= 1'b0;
         wt_addr <= '0;
         wt_data <= '0;
         for (int s = 0; s < SETS; s++) begin
            val_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) dirty_q[s][w] <= '0;
         end
      end else begin
         wt_we <= hit_wr && wt_mode;
         if (hit_wr) begin
            wt_addr <= cpu_addr;
            wt_data <= cpu_wdata;
         end
         case (st)
            ST_IDLE: begin
               if (flush) begin
                  st   <= ST_SWEEP;
                  fcnt <= '0;
               end else if (miss) begin
                  vway <= pick;
                  cnt  <= '0;
                  st   <= (|pdirty) ? ST_EVICT : ST_FILL;
               end
               if (hit_wr && !wt_mode) dirty_q[set_i][hway][word_i] <= 1'b1;
            end
            ST_EVICT: begin
               if (mem_ack) begin
                  dirty_q[set_i][vway][ev_word] <= 1'b0;
                  if ((vdirty & ~ev_mask) == '0) st <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST_W) begin
                     val_q[set_i][vway] <= 1'b1;
                     st <= ST_IDLE;
                  end
               end
            end
            default: begin
               val_q[fcnt] <= '0;
               for (int w = 0; w < WAYS; w++) dirty_q[fcnt][w] <= '0;
               fcnt <= fcnt + 1'b1;
               if (fcnt == LAST_S) st <= ST_IDLE;
            end
         endcase
      end
   end

   // tag and data arrays
   always_ff @(posedge clk) begin
      if (hit_wr) data_q[set_i][hway][word_i] <= cpu_wdata;
      if (st == ST_FILL && mem_ack) begin
         data_q[set_i][vway][cnt] <= mem_rdata;
         if (cnt == LAST_W) tag_q[set_i][vway] <= tag_i;
      end
   end
endmodule

// File: rtl/dc_chk.sv
module dc_chk #(
   parameter int SETS = 64
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wt_mode,
   input logic        busy,
   input logic        cpu_req,
   input logic        cpu_we,
   input logic        cpu_ack,
   input logic        mem_req,
   input logic        mem_we,
   input logic        mem_ack,
   input logic [31:0] mem_addr,
   input logic        wt_we
);
   localparam int RUN_W = $clog2(SETS) + 2;
   logic [RUN_W-1:0] brun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    brun <= '0;
      else if (busy) brun <= brun + 1'b1;
      else           brun <= '0;
   end

   // R2: an acknowledge only answers a live request and never overlaps memory traffic
   p_ack_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> (cpu_req && !mem_req));

   // R3: memory request and address hold until the memory answers
   p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R5: a strobe follows an acknowledged store issued in write-through mode
   p_wt_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wt_we |-> $past(cpu_ack && cpu_we && wt_mode));

   // R4: write-back mode stores produce no strobe
   p_wb_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_we && !wt_mode) |=> !wt_we);

   // R7: nothing is acknowledged while the sweep runs
   p_sweep_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!cpu_ack && !mem_req));

   // R7: the sweep lasts no more than one cycle per set
   p_sweep_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (brun < RUN_W'(SETS)));

   // R4: memory writes happen only outside the sweep
   p_wr_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !busy);
endmodule

bind dcache4w dc_chk #(.SETS(SETS)) u_chk (
   .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode), .busy(busy),
   .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ack(cpu_ack),
   .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
   .mem_addr(mem_addr), .wt_we(wt_we));

// File: tb/sim_dcache4w.sv
module sim_dcache4w;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wt_mode = 1'b1;
   logic        flush = 1'b0;
   logic        busy;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ack;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        wt_we;
   logic [31:0] wt_addr, wt_data;

   always #10 clk = ~clk;

   dcache4w u0 (.*);

   int checks = 0, fails = 0;
   bit done = 1'b0;

   logic [31:0] bmem   [8192];
   logic [31:0] refm   [8192];
   logic [31:0] rlog_a [16];
   logic [31:0] wlog_a [16];
   logic [31:0] wlog_d [16];
   int rn = 0, wn = 0, wtn = 0, mdly = 0;

   function automatic logic [31:0] init_word(input int i);
      return (i * 32'h9E3779B1) ^ 32'h0000_5A5A;
   endfunction

   function automatic int widx(input logic [31:0] a);
      return int'(a[14:2]);
   endfunction

   function automatic logic [31:0] mk_addr(input int tag, input int set, input int word);
      return {17'd0, 5'(tag), 6'(set), 2'(word), 2'b00};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // bench memory: answers on the second falling edge of a request
   always @(negedge clk) begin
      if (wt_we) begin
         bmem[widx(wt_addr)] = wt_data;
         wtn++;
      end
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         if (mdly == 1) begin
            mdly = 0;
            mem_ack = 1'b1;
            if (mem_we) begin
               bmem[widx(mem_addr)] = mem_wdata;
               if (wn < 16) begin
                  wlog_a[wn] = mem_addr;
                  wlog_d[wn] = mem_wdata;
               end
               wn++;
            end else begin
               mem_rdata = bmem[widx(mem_addr)];
               if (rn < 16) rlog_a[rn] = mem_addr;
               rn++;
            end
         end else begin
            mdly++;
         end
      end
   end

   // one processor access; lat counts falling edges waited before the ack
   task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output int lat);
      @(negedge clk);
      rn = 0; wn = 0; lat = 0;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      forever begin
         #5;
         if (cpu_ack) begin
            rd = cpu_rdata;
            break;
         end
         @(negedge clk);
         lat++;
      end
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
      if (we) begin
         refm[widx(a)] = d;
         if (wt_mode) begin
            chk(wt_we === 1'b1, "R5", "strobe after store", {31'd0, wt_we}, 32'd1);
            chk(wt_addr === a && wt_data === d, "R5", "strobe address/data", wt_data, d);
         end else begin
            chk(wt_we === 1'b0, "R4", "no strobe in write-back", {31'd0, wt_we}, 32'd0);
         end
      end
   endtask

   task automatic load_chk(input logic [31:0] a, input string req, output int lat);
      logic [31:0] rd;
      cpu_op(1'b0, a, '0, rd, lat);
      chk(rd === refm[widx(a)], req, "load data", rd, refm[widx(a)]);
   endtask

   task automatic rand_phase(input int n);
      int lat;
      logic [31:0] rd, a, d;
      for (int i = 0; i < n; i++) begin
         a = mk_addr($urandom_range(0, 7), $urandom_range(0, 2), $urandom_range(0, 3));
         if ($urandom_range(0, 1) == 1) begin
            d = $urandom;
            cpu_op(1'b1, a, d, rd, lat);
         end else begin
            load_chk(a, "R9", lat);
         end
      end
   endtask

   initial begin
      int lat, wt0, bcnt, ackseen, nwr;
      logic [31:0] rd, a;
      void'($urandom(32'd1357));
      for (int i = 0; i < 8192; i++) begin
         bmem[i] = init_word(i);
         refm[i] = init_word(i);
      end
      repeat (3) @(negedge clk);
      #5;
      chk(busy === 1'b0 && cpu_ack === 1'b0 && mem_req === 1'b0 && wt_we === 1'b0,
          "R8", "outputs in reset", {28'd0, busy, cpu_ack, mem_req, wt_we}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #5;
      chk(busy === 1'b0 && mem_req === 1'b0, "R8", "idle after reset",
          {30'd0, busy, mem_req}, 32'd0);

      // R3: miss on an empty cache reads the full line in order, R2: repeat hits
      a = mk_addr(2, 1, 2);
      load_chk(a, "R3", lat);
      chk(rn == 4, "R3", "refill read count", rn, 4);
      for (int i = 0; i < 4; i++)
         chk(rlog_a[i] === mk_addr(2, 1, i), "R3", "refill address order", rlog_a[i],
             mk_addr(2, 1, i));
      load_chk(a, "R2", lat);
      chk(lat == 0, "R2", "hit latency", lat, 0);
      chk(rn == 0 && wn == 0, "R2", "hit has no memory traffic", rn + wn, 0);

      // R1/R6: four tags fill an empty set and all stay resident
      for (int t = 0; t < 4; t++) load_chk(mk_addr(t, 7, 0), "R1", lat);
      for (int t = 0; t < 4; t++) begin
         load_chk(mk_addr(t, 7, 3), "R6", lat);
         chk(lat == 0 && rn == 0, "R1", "set holds four tags", lat, 0);
      end

      // R5: write-through store, strobe width and no later write-back
      cpu_op(1'b1, mk_addr(0, 7, 1), 32'hC0DE_0001, rd, lat);
      @(negedge clk);
      chk(wt_we === 1'b0, "R5", "strobe is one cycle", {31'd0, wt_we}, 32'd0);
      nwr = 0;
      for (int t = 8; t < 20; t++) begin
         load_chk(mk_addr(t, 7, 0), "R5", lat);
         nwr += wn;
      end
      chk(nwr == 0, "R5", "no memory write on eviction", nwr, 0);

      // R9 + R5: random write-through traffic
      wt0 = wtn;
      rand_phase(250);

      // R7: flush sweep
      a = mk_addr(2, 1, 2);
      load_chk(a, "R7", lat);
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
      bcnt = 0; ackseen = 0;
      for (int i = 0; i < 70; i++) begin
         #5;
         if (busy === 1'b1) bcnt++;
         if (cpu_ack === 1'b1 && busy === 1'b1) ackseen++;
         if (busy !== 1'b1) break;
         @(negedge clk);
      end
      cpu_req = 1'b0;
      chk(bcnt == 64, "R7", "busy cycles", bcnt, 64);
      chk(ackseen == 0, "R7", "no ack while busy", ackseen, 0);
      load_chk(a, "R7", lat);
      chk(rn == 4, "R7", "resident line misses after flush", rn, 4);

      // R4: write-back of dirty words only, ascending order
      wt_mode = 1'b0;
      wt0 = wtn;
      cpu_op(1'b1, mk_addr(0, 9, 3), 32'hD00D_0003, rd, lat);
      cpu_op(1'b1, mk_addr(0, 9, 1), 32'hD00D_0001, rd, lat);
      chk(lat == 0, "R4", "second store hits", lat, 0);
      nwr = 0;
      for (int k = 0; k < 60 && nwr == 0; k++) begin
         load_chk(mk_addr(1 + (k % 7), 9, 0), "R4", lat);
         nwr = wn;
      end
      chk(nwr == 2, "R4", "dirty word writes", nwr, 2);
      chk(wlog_a[0] === mk_addr(0, 9, 1) && wlog_d[0] === 32'hD00D_0001, "R4",
          "first write-back word", wlog_a[0], mk_addr(0, 9, 1));
      chk(wlog_a[1] === mk_addr(0, 9, 3) && wlog_d[1] === 32'hD00D_0003, "R4",
          "second write-back word", wlog_a[1], mk_addr(0, 9, 3));

      // R9 + R4: random write-back traffic
      rand_phase(350);
      chk(wtn == wt0, "R4", "no strobes in write-back mode", wtn, wt0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule